// File: doc/BRIEF.md
# Modal Device Command Register

This block puts two attached on-chip resources behind one 8-bit register location that has a read strobe and a write strobe. After reset the location is in a select mode. In that mode software chooses which resource the location will address, then leaves select mode to attach that resource. Writing a value with bit 7 set returns the location to select mode at any time.

With the identifier resource attached, each read returns one bit of a serial stream in bit 0. The stream opens with an 8-bit length prefix, followed by the chip-unique identifier, and is shifted out MSB first. A write reloads the stream from its start. With the converter resource attached, reads return the converter's busy level and two sticky event flags that clear when read. Writes drive one-cycle reset and start-conversion pulses toward the converter.

The read value is combinational from the current state. A read's side effects (stream advance, flag clear) take place at the clock edge that ends the cycle in which `rd_i` is high.

Top module: `devcmd_port`

## Requirements
- R1: After `rst_ni` is released, the block is in select mode with device code 00, reads return 0x80, and both converter pulse outputs are low.
- R2: In select mode a read returns 0x80 OR'd with the selected device code in bits 1:0. The codes are 00 none, 01 identifier, 10 converter, 11 reserved.
- R3: In select mode, a write with bits 7 and 6 both set loads bits 1:0 as the device code. A write with bit 7 set and bit 6 clear leaves the code unchanged.
- R4: In select mode, a write with bit 7 clear leaves select mode and attaches the selected device. The other bits of that write cause no converter pulse and leave the code unchanged.
- R5: With a device attached, a write with bit 7 set returns to select mode and has no other effect. It causes no pulse, leaves the code unchanged and leaves the converter flags unchanged.
- R6: With the identifier attached, a read returns the current stream bit in bit 0, with bits 7:1 zero, and the next read returns the following bit. The stream is the 8-bit value ID_W followed by the ID_W identifier bits, both MSB first. Once the stream is exhausted, reads return 0.
- R7: The stream reloads from its start, taking a fresh sample of `id_bits_i`, on a write with bit 7 clear while the identifier is attached, and on every entry into identifier mode.
- R8: With the converter attached, a read returns busy in bit 6, the end-of-conversion flag in bit 1, the end-of-sequence flag in bit 0, and zero in all other bits.
- R9: Each flag is set by a one-cycle event input and cleared by a converter-mode read. When an event and a clearing read fall in the same cycle, the read returns the old value and the flag ends up set.
- R10: With the converter attached, a write with bit 7 clear produces, in the next cycle, a one-cycle `adc_rst_o` pulse if bit 6 is set and a one-cycle `adc_convst_o` pulse if bit 0 is set.
- R11: With code 00 or 11 attached, reads return 0x00 and every write other than the bit-7 escape is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 8 | Write data |
| rd_i | input | 1 | Read strobe; side effects at the closing edge |
| rd_data_o | output | 8 | Read data for the current state |
| id_bits_i | input | ID_W | Chip-unique identifier value |
| adc_busy_i | input | 1 | Converter busy level |
| adc_eoc_i | input | 1 | End-of-conversion event, one cycle |
| adc_eos_i | input | 1 | End-of-sequence event, one cycle |
| adc_rst_o | output | 1 | Converter reset pulse |
| adc_convst_o | output | 1 | Converter start-conversion pulse |

## Verification
The clash that matters is between a converter event input and a clearing read of its flag in the same cycle. The bench raises `adc_eoc_i` or `adc_eos_i` during the very cycle in which `rd_i` is high in converter mode. It does this once with the flag already set and once with it clear. It judges the result by two things: the value returned in that cycle (the old flag), and the value returned by the next read (the flag set).

// File: rtl/devcmd_pkg.sv
package devcmd_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned ESC_BIT = 7;
  localparam int unsigned CHG_BIT = 6;
  localparam int unsigned LEN_W   = 8;

  typedef enum logic [1:0] {
    DEV_NONE = 2'b00,
    DEV_ID   = 2'b01,
    DEV_ADC  = 2'b10,
    DEV_RSVD = 2'b11
  } dev_e;
endpackage

// File: rtl/devcmd_fsm.sv
module devcmd_fsm
  import devcmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_i,
  output logic             sel_mode_o,
  output dev_e             dev_o,
  output logic             dev_wr_o,
  output logic             dev_rd_o,
  output logic             enter_o
);
  logic sel_mode_q;
  dev_e dev_q;
  logic esc;

  assign esc = wr_data_i[ESC_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_mode_q <= 1'b1;
      dev_q      <= DEV_NONE;
    end else if (wr_i) begin
      if (sel_mode_q) begin
        if (!esc) sel_mode_q <= 1'b0;
        else if (wr_data_i[CHG_BIT]) dev_q <= dev_e'(wr_data_i[1:0]);
      end else if (esc) begin
        sel_mode_q <= 1'b1;
      end
    end
  end

  assign sel_mode_o = sel_mode_q;
  assign dev_o      = dev_q;
  assign dev_wr_o   = wr_i & ~sel_mode_q & ~esc;
  assign dev_rd_o   = rd_i & ~sel_mode_q;
  assign enter_o    = wr_i & sel_mode_q & ~esc;

  AST_ESC_TO_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && esc) |=> sel_mode_q); // R5
  AST_EXIT_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_mode_q && !esc) |=> (!sel_mode_q && $stable(dev_q))); // R4
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i && sel_mode_q && esc && wr_data_i[CHG_BIT])) |=> $stable(dev_q)); // R3
endmodule

// File: rtl/devcmd_id_shifter.sv
module devcmd_id_shifter
  import devcmd_pkg::*;
#(
  parameter int unsigned ID_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ID_W-1:0] id_i,
  input  logic            load_i,
  input  logic            shift_i,
  output logic            bit_o
);
  localparam int unsigned SEQ_W = LEN_W + ID_W;
  localparam int unsigned CNT_W = $clog2(SEQ_W + 1);
  localparam logic [LEN_W-1:0] LEN_VAL = LEN_W'(ID_W);

  logic [SEQ_W-1:0] seq_q;
  logic [CNT_W-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q  <= '0;
      left_q <= '0;
    end else if (load_i) begin
      seq_q  <= {LEN_VAL, id_i};
      left_q <= CNT_W'(SEQ_W);
    end else if (shift_i) begin
      seq_q <= {seq_q[SEQ_W-2:0], 1'b0};
      if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign bit_o = seq_q[SEQ_W-1];

  AST_DRAINED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (left_q == '0) |-> !bit_o); // R6
  AST_RELOAD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (left_q == CNT_W'(SEQ_W))); // R7
endmodule

// File: rtl/devcmd_adc_ctl.sv
module devcmd_adc_ctl
  import devcmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eoc_i,
  input  logic             eos_i,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             eoc_o,
  output logic             eos_o,
  output logic             adc_rst_o,
  output logic             adc_convst_o
);
  logic eoc_q, eos_q, rst_q, cst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_q <= 1'b0;
      eos_q <= 1'b0;
      rst_q <= 1'b0;
      cst_q <= 1'b0;
    end else begin
      // event wins over a clearing read in the same cycle
      eoc_q <= eoc_i | (eoc_q & ~clr_i);
      eos_q <= eos_i | (eos_q & ~clr_i);
      rst_q <= wr_i & wr_data_i[6];
      cst_q <= wr_i & wr_data_i[0];
    end
  end

  assign eoc_o        = eoc_q;
  assign eos_o        = eos_q;
  assign adc_rst_o    = rst_q;
  assign adc_convst_o = cst_q;

  AST_EOC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> eoc_q); // R9
  AST_EOS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_i |=> eos_q); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !eoc_i && eoc_q) |=> eoc_q); // R9
  AST_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (!adc_rst_o && !adc_convst_o)); // R10
endmodule

// File: rtl/devcmd_port.sv
module devcmd_port
  import devcmd_pkg::*;
#(
  parameter int unsigned ID_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [7:0]      wr_data_i,
  input  logic            rd_i,
  output logic [7:0]      rd_data_o,
  input  logic [ID_W-1:0] id_bits_i,
  input  logic            adc_busy_i,
  input  logic            adc_eoc_i,
  input  logic            adc_eos_i,
  output logic            adc_rst_o,
  output logic            adc_convst_o
);
  logic sel_mode, dev_wr, dev_rd, enter;
  dev_e dev;
  logic id_bit, eoc, eos;
  logic is_id, is_adc;

  devcmd_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .wr_data_i  (wr_data_i),
    .rd_i       (rd_i),
    .sel_mode_o (sel_mode),
    .dev_o      (dev),
    .dev_wr_o   (dev_wr),
    .dev_rd_o   (dev_rd),
    .enter_o    (enter)
  );

  assign is_id  = (dev == DEV_ID);
  assign is_adc = (dev == DEV_ADC);

  devcmd_id_shifter #(.ID_W(ID_W)) u_id (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .id_i    (id_bits_i),
    .load_i  (is_id & (dev_wr | enter)),
    .shift_i (is_id & dev_rd),
    .bit_o   (id_bit)
  );

  devcmd_adc_ctl u_adc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .eoc_i        (adc_eoc_i),
    .eos_i        (adc_eos_i),
    .clr_i        (is_adc & dev_rd),
    .wr_i         (is_adc & dev_wr),
    .wr_data_i    (wr_data_i),
    .eoc_o        (eoc),
    .eos_o        (eos),
    .adc_rst_o    (adc_rst_o),
    .adc_convst_o (adc_convst_o)
  );

  always_comb begin
    rd_data_o = '0;
    if (sel_mode) begin
      rd_data_o[ESC_BIT] = 1'b1;
      rd_data_o[1:0]     = dev;
    end else begin
      unique case (dev)
        DEV_ID:  rd_data_o[0] = id_bit;
        DEV_ADC: begin
          rd_data_o[6] = adc_busy_i;
          rd_data_o[1] = eoc;
          rd_data_o[0] = eos;
        end
        default: rd_data_o = '0;
      endcase
    end
  end

  AST_DEV_MSB_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_mode |-> !rd_data_o[7]); // R8
  AST_SEL_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_mode |-> (rd_data_o[7] && rd_data_o[5:2] == 4'd0)); // R2
endmodule

// File: tb/test_devcmd_port.sv
module test_devcmd_port;
  localparam int unsigned ID_W = 16;
  localparam int unsigned SEQ_W = 8 + ID_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic [ID_W-1:0] id_bits_i = 16'hA5C3;
  logic adc_busy_i = 1'b0, adc_eoc_i = 1'b0, adc_eos_i = 1'b0;
  logic adc_rst_o, adc_convst_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  devcmd_port #(.ID_W(ID_W)) i_devcmd_port (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk_i); wr_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic rd_ev(logic [1:0] ev, logic [7:0] exp, string tag);
    @(negedge clk_i); rd_i = 1'b1; adc_eoc_i = ev[1]; adc_eos_i = ev[0];
    #1 chk(tag, rd_data_o, exp);
    @(negedge clk_i); rd_i = 1'b0; adc_eoc_i = 1'b0; adc_eos_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] exp, string tag);
    rd_ev(2'b00, exp, tag);
  endtask

  task automatic pulse_chk(logic r, logic c, string tag);
    chk(tag, {6'd0, adc_rst_o, adc_convst_o}, {6'd0, r, c});
    @(negedge clk_i);
    chk(tag, {6'd0, adc_rst_o, adc_convst_o}, 8'd0);
  endtask

  task automatic ev(logic [1:0] e);
    @(negedge clk_i); adc_eoc_i = e[1]; adc_eos_i = e[0];
    @(negedge clk_i); adc_eoc_i = 1'b0; adc_eos_i = 1'b0;
  endtask

  task automatic sweep_id(logic [ID_W-1:0] id);
    logic [SEQ_W-1:0] seq;
    seq = {8'(ID_W), id};
    for (int i = 0; i < SEQ_W + 4; i++) begin
      logic b;
      b = (i < SEQ_W) ? seq[SEQ_W-1-i] : 1'b0;
      rd({7'd0, b}, "R6 stream bit");
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 reset read", rd_data_o, 8'h80);
    chk("R1 reset pulses", {6'd0, adc_rst_o, adc_convst_o}, 8'd0);
    // R2 R3 code sweep
    for (int c = 0; c < 4; c++) begin
      wr(8'hC0 | 8'(c));
      rd(8'h80 | 8'(c), "R2 R3 select code");
    end
    wr(8'h82); rd(8'h83, "R3 bit6 clear keeps code");
    wr(8'hBF); rd(8'h83, "R3 bit6 clear keeps code");
    // R11 reserved code attached
    wr(8'h3F); rd(8'h00, "R11 reserved read");
    wr(8'h41); pulse_chk(1'b0, 1'b0, "R11 reserved write ignored");
    rd(8'h00, "R11 still attached");
    wr(8'h80); rd(8'h83, "R5 escape");
    wr(8'hC0); wr(8'h00); rd(8'h00, "R11 none read");
    wr(8'h80);
    // R4 exit with extra bits
    wr(8'hC2); wr(8'h41); pulse_chk(1'b0, 1'b0, "R4 exit no pulse");
    rd(8'h00, "R4 converter attached");
    // R10
    wr(8'h41); pulse_chk(1'b1, 1'b1, "R10 both pulses");
    wr(8'h01); pulse_chk(1'b0, 1'b1, "R10 convst only");
    wr(8'h40); pulse_chk(1'b1, 1'b0, "R10 reset only");
    // R8
    adc_busy_i = 1'b1; rd(8'h40, "R8 busy"); adc_busy_i = 1'b0;
    // R9
    ev(2'b10); rd(8'h02, "R9 eoc set"); rd(8'h00, "R9 eoc cleared");
    ev(2'b01); rd(8'h01, "R9 eos set"); rd(8'h00, "R9 eos cleared");
    rd_ev(2'b10, 8'h00, "R9 clash clear flag"); rd(8'h02, "R9 clash sets");
    rd(8'h00, "R9 cleared");
    ev(2'b01);
    rd_ev(2'b01, 8'h01, "R9 clash set flag"); rd(8'h01, "R9 stays set");
    rd(8'h00, "R9 cleared");
    // R5 escape from converter mode
    ev(2'b11); adc_busy_i = 1'b1;
    wr(8'hC1); pulse_chk(1'b0, 1'b0, "R5 escape no pulse");
    rd(8'h82, "R5 code unchanged");
    wr(8'h00); rd(8'h43, "R5 flags kept"); adc_busy_i = 1'b0;
    rd(8'h00, "R8 flags cleared");
    // R6 R7
    wr(8'h80); wr(8'hC1); wr(8'h00);
    sweep_id(16'hA5C3);
    id_bits_i = 16'h3C96;
    wr(8'h00);
    sweep_id(16'h3C96);
    for (int i = 0; i < 5; i++) rd_ev(2'b00, rd_data_o, "R6 partial");
    id_bits_i = 16'h0001;
    wr(8'h80); wr(8'h00);
    sweep_id(16'h0001);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule